// File: doc/BRIEF.md
# Latched Fault Flag and Supply Lockout Controller

This block sits between a set of analog fault comparators and the serial-bus register file of a supply controller. It keeps three sticky fault flags for the host to poll: output overload, overtemperature, and low input power. A flag goes high as soon as its synchronized cause appears. It stays high until the cause has gone and the host has then read the status register. The low-input-power flag also drives an active-low fault pin.

The block also holds the small control register that the host writes. This register has four output voltage-select bits and a thermal restart policy bit. While the supply sits below its lockout threshold, the register and the flags are held at zero and host writes are ignored. Once the supply has risen past a higher release threshold, the lockout is released synchronously. When overtemperature occurs, the power stages are switched off. The policy bit then chooses between two outcomes. With the bit at 0, the output resumes on its own when the heat goes away. With the bit at 1, the voltage-select bits are wiped and the output stays off until the host programs them again.

Top module: `diag_status_latch`

## Requirements
- R1: After reset with no active cause, `status` reads 3'b000. The bit positions are: bit 0 overload, bit 1 overtemperature, bit 2 low input power.
- R2: A raw cause that goes high is seen in its status bit after the third rising clock edge (two synchronizer stages, then the latch). It is not seen after the second edge.
- R3: A status read while the synchronized cause is still high leaves the flag at 1.
- R4: Once the synchronized cause is low, the flag stays 1 until a read strobe is sampled. It clears on the edge that samples that first read.
- R5: `fault_n` is 0 exactly while the low-input-power status bit is 1.
- R6: While `uv_trip` is high, or `por_n` is low, `vsel`, `therm_hold` and `status` are forced to 0 at once, without waiting for a clock edge.
- R7: Lockout persists after `uv_trip` falls until `uv_clear` is sampled high. Writes are ignored during lockout and for the next two edges after that. A write strobed on the fourth edge after `uv_clear` is accepted.
- R8: `stage_en` drops after the second rising edge following a raw overtemperature rise, under either restart policy.
- R9: With `therm_hold` = 0, `vsel` keeps its value through overtemperature. `stage_en` returns two edges after the raw cause falls.
- R10: With `therm_hold` = 1, `vsel` is cleared on the third edge after the raw overtemperature rise. `vsel_clr` is high for exactly that one cycle. `vsel` writes are ignored while the cause lasts, and `stage_en` stays 0 afterwards until the host writes a nonzero `vsel`.
- R11: `stage_en` is 1 only while `vsel` is nonzero and no synchronized overtemperature is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| uv_trip | input | 1 | Supply below lockout threshold |
| uv_clear | input | 1 | Supply above release threshold |
| ovl_raw | input | 1 | Raw overload comparator output |
| otmp_raw | input | 1 | Raw overtemperature comparator output |
| pwr_low_raw | input | 1 | Raw low-input-power comparator output |
| stat_rd | input | 1 | One-cycle strobe: host read of status |
| wr_en | input | 1 | One-cycle strobe: host write of control register |
| wr_vsel | input | 4 | Voltage-select value to write |
| wr_therm_hold | input | 1 | Thermal restart policy value to write |
| vsel | output | 4 | Current voltage-select bits |
| therm_hold | output | 1 | Current thermal restart policy bit |
| stage_en | output | 1 | Power stages enabled |
| vsel_clr | output | 1 | One-cycle pulse: voltage-select bits wiped by thermal fault |
| status | output | 3 | Latched fault flags |
| fault_n | output | 1 | Active-low fault pin (low input power) |

## Verification
Every raw cause passes two synchronizer stages. Each flag therefore rises after the third edge, while `stage_en` falls after the second edge, and the `vsel` wipe and its `vsel_clr` pulse appear after the third edge. A read clears a flag on the single edge that samples it. Lockout release needs one edge for the hysteresis flop and two for the reset synchronizer, so the first write that counts is the one on the fourth edge. The bench drives each input on a falling edge and then waits a known number of rising edges before it samples. At the key latencies it checks both the cycle before the change and the cycle of the change, so a result that arrives one edge early or one edge late is caught.

// File: rtl/diag_pkg.sv
package diag_pkg;
   localparam int NUM_FLAGS = 3;
   typedef enum int {
      FLG_OVERLOAD = 0,
      FLG_OVERTEMP = 1,
      FLG_PWRLOW   = 2
   } flag_idx_e;
endpackage

// File: rtl/diag_sync.sv
module diag_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] pipe [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("diag_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $error("diag_sync: WIDTH must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/diag_lockout.sv
module diag_lockout #(
   parameter int RST_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic uv_trip,
   input  logic uv_clear,
   output logic rst_n
);
   logic                  lock_set;
   logic                  lock_q;
   logic [RST_STAGES-1:0] rs_q;

   initial begin
      assert (RST_STAGES >= 2) else $error("diag_lockout: RST_STAGES must be at least 2");
   end

   assign lock_set = uv_trip | ~por_n;

   // hysteresis: set by the low comparator, cleared only by the high one
   always_ff @(posedge clk or posedge lock_set) begin
      if (lock_set)      lock_q <= 1'b1;
      else if (uv_clear) lock_q <= 1'b0;
   end

   // asynchronous assertion, synchronous release
   generate
      if (RST_STAGES == 1) begin : g_one
         always_ff @(posedge clk or posedge lock_q) begin
            if (lock_q) rs_q <= '0;
            else        rs_q <= 1'b1;
         end
      end else begin : g_many
         always_ff @(posedge clk or posedge lock_q) begin
            if (lock_q) rs_q <= '0;
            else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   assign rst_n = rs_q[RST_STAGES-1];

   // R7: lockout does not release without the high comparator
   a_r7_hold_hysteresis : assert property (@(posedge clk) disable iff (lock_set)
      (lock_q && !uv_clear) |=> lock_q);
endmodule

// File: rtl/diag_flag.sv
module diag_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic cause,
   input  logic rd,
   output logic flag
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flag_q <= 1'b0;
      else if (cause)         flag_q <= 1'b1;
      else if (flag_q && rd)  flag_q <= 1'b0;
   end

   assign flag = flag_q;

   // R2: a present cause is latched on the next edge
   a_r2_set_on_cause : assert property (@(posedge clk) disable iff (!rst_n)
      cause |=> flag);
   // R3: a read never clears while the cause is present
   a_r3_read_with_cause : assert property (@(posedge clk) disable iff (!rst_n)
      (flag && cause && rd) |=> flag);
   // R4: without a read the flag holds
   a_r4_hold_no_read : assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !rd) |=> flag);
endmodule

// File: rtl/diag_ctrl_reg.sv
module diag_ctrl_reg #(
   parameter int VSEL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ot_live,
   input  logic              wr_en,
   input  logic [VSEL_W-1:0] wr_vsel,
   input  logic              wr_hold,
   output logic [VSEL_W-1:0] vsel,
   output logic              hold,
   output logic              clr_pulse,
   output logic              stage_en
);
   logic [VSEL_W-1:0] vsel_q;
   logic              hold_q;
   logic              ot_d;
   logic              clr_q;
   logic              wipe;

   initial begin
      assert (VSEL_W >= 1) else $error("diag_ctrl_reg: VSEL_W must be at least 1");
   end

   assign wipe = hold_q & ot_live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsel_q <= '0;
         hold_q <= 1'b0;
         ot_d   <= 1'b0;
         clr_q  <= 1'b0;
      end else begin
         ot_d  <= ot_live;
         clr_q <= ot_live & ~ot_d & hold_q;
         if (wipe)       vsel_q <= '0;
         else if (wr_en) vsel_q <= wr_vsel;
         if (wr_en)      hold_q <= wr_hold;
      end
   end

   assign vsel      = vsel_q;
   assign hold      = hold_q;
   assign clr_pulse = clr_q;
   assign stage_en  = (|vsel_q) & ~ot_live;

   // R10: with the hold policy the select bits stay zero during the event
   a_r10_vsel_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (hold && ot_live) |=> (vsel == '0));
   // R10: the wipe request lasts a single cycle
   a_r10_clr_single : assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> !clr_pulse);
   // R9: with auto restart the select bits survive the event
   a_r9_vsel_kept : assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && ot_live && !wr_en) |=> $stable(vsel));
endmodule

// File: rtl/diag_status_latch.sv
module diag_status_latch #(
   parameter int VSEL_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int RST_STAGES  = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              uv_trip,
   input  logic              uv_clear,
   input  logic              ovl_raw,
   input  logic              otmp_raw,
   input  logic              pwr_low_raw,
   input  logic              stat_rd,
   input  logic              wr_en,
   input  logic [VSEL_W-1:0] wr_vsel,
   input  logic              wr_therm_hold,
   output logic [VSEL_W-1:0] vsel,
   output logic              therm_hold,
   output logic              stage_en,
   output logic              vsel_clr,
   output logic [diag_pkg::NUM_FLAGS-1:0] status,
   output logic              fault_n
);
   import diag_pkg::*;

   logic                 rst_n;
   logic [NUM_FLAGS-1:0] raw_vec;
   logic [NUM_FLAGS-1:0] live_vec;
   logic [NUM_FLAGS-1:0] flag_vec;

   diag_lockout #(.RST_STAGES(RST_STAGES)) u_lock (
      .clk(clk), .por_n(por_n), .uv_trip(uv_trip), .uv_clear(uv_clear), .rst_n(rst_n)
   );

   assign raw_vec[FLG_OVERLOAD] = ovl_raw;
   assign raw_vec[FLG_OVERTEMP] = otmp_raw;
   assign raw_vec[FLG_PWRLOW]   = pwr_low_raw;

   diag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_vec), .q(live_vec)
   );

   generate
      for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
         diag_flag u_flag (
            .clk(clk), .rst_n(rst_n), .cause(live_vec[g]), .rd(stat_rd), .flag(flag_vec[g])
         );
      end
   endgenerate

   diag_ctrl_reg #(.VSEL_W(VSEL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ot_live(live_vec[FLG_OVERTEMP]),
      .wr_en(wr_en), .wr_vsel(wr_vsel), .wr_hold(wr_therm_hold),
      .vsel(vsel), .hold(therm_hold), .clr_pulse(vsel_clr), .stage_en(stage_en)
   );

   assign status  = flag_vec;
   assign fault_n = ~flag_vec[FLG_PWRLOW];

   // R8: no stage power while the flag shows a present overtemperature
   a_r8_stage_off : assert property (@(posedge clk) disable iff (!rst_n)
      (live_vec[FLG_OVERTEMP]) |=> (status[FLG_OVERTEMP] && (!stage_en || !live_vec[FLG_OVERTEMP])));
   // R6: reset leaves nothing latched
   a_r6_clear_in_reset : assert property (@(posedge clk)
      !rst_n |-> (status == '0 && vsel == '0 && !therm_hold));
endmodule

// File: tb/sim_diag_status_latch.sv
module sim_diag_status_latch;
   logic       clk = 0;
   logic       por_n = 0, uv_trip = 0, uv_clear = 1;
   logic       ovl_raw = 0, otmp_raw = 0, pwr_low_raw = 0;
   logic       stat_rd = 0, wr_en = 0, wr_therm_hold = 0;
   logic [3:0] wr_vsel = 0;
   logic [3:0] vsel;
   logic       therm_hold, stage_en, vsel_clr, fault_n;
   logic [2:0] status;
   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   diag_status_latch u0 (
      .clk(clk), .por_n(por_n), .uv_trip(uv_trip), .uv_clear(uv_clear),
      .ovl_raw(ovl_raw), .otmp_raw(otmp_raw), .pwr_low_raw(pwr_low_raw),
      .stat_rd(stat_rd), .wr_en(wr_en), .wr_vsel(wr_vsel), .wr_therm_hold(wr_therm_hold),
      .vsel(vsel), .therm_hold(therm_hold), .stage_en(stage_en), .vsel_clr(vsel_clr),
      .status(status), .fault_n(fault_n)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(logic [3:0] v, logic h);
      wr_en = 1; wr_vsel = v; wr_therm_hold = h;
      step(1);
      wr_en = 0;
   endtask

   task automatic host_read();
      stat_rd = 1;
      step(1);
      stat_rd = 0;
   endtask

   task automatic t_reset();
      step(1);
      por_n = 1;
      step(4);
      chk("R1 status after reset", status, 0);
      chk("R1 vsel after reset", vsel, 0);
      chk("R5 fault_n idle", fault_n, 1);
   endtask

   task automatic t_overload();
      ovl_raw = 1;
      step(2);
      chk("R2 overload not yet latched", status, 0);
      step(1);
      chk("R2 overload bit0 latched", status, 3'b001);
      host_read();
      chk("R3 read with cause keeps flag", status[0], 1);
      ovl_raw = 0;
      step(2);
      step(3);
      chk("R4 flag held without read", status[0], 1);
      host_read();
      chk("R4 first read clears", status[0], 0);
   endtask

   task automatic t_pwr_low();
      pwr_low_raw = 1;
      step(3);
      chk("R1 low-power bit2", status, 3'b100);
      chk("R5 fault_n low", fault_n, 0);
      pwr_low_raw = 0;
      step(3);
      chk("R5 fault_n low until read", fault_n, 0);
      host_read();
      chk("R5 fault_n released", fault_n, 1);
   endtask

   task automatic t_therm_auto();
      host_write(4'b0101, 0);
      chk("R11 stage on with vsel", stage_en, 1);
      otmp_raw = 1;
      step(1);
      chk("R8 stage still on at edge 1", stage_en, 1);
      step(1);
      chk("R8 stage off at edge 2", stage_en, 0);
      step(1);
      chk("R1 overtemp bit1", status, 3'b010);
      chk("R9 vsel kept", vsel, 4'b0101);
      otmp_raw = 0;
      step(1);
      chk("R9 stage off one edge after fall", stage_en, 0);
      step(1);
      chk("R9 stage back", stage_en, 1);
      chk("R9 vsel still kept", vsel, 4'b0101);
      host_read();
      chk("R4 overtemp flag cleared", status, 0);
   endtask

   task automatic t_therm_hold();
      host_write(4'b1010, 1);
      otmp_raw = 1;
      step(2);
      chk("R8 stage off with hold policy", stage_en, 0);
      chk("R10 vsel not yet wiped", vsel, 4'b1010);
      chk("R10 no pulse yet", vsel_clr, 0);
      step(1);
      chk("R10 vsel wiped", vsel, 0);
      chk("R10 pulse", vsel_clr, 1);
      step(1);
      chk("R10 pulse single", vsel_clr, 0);
      host_write(4'b0011, 1);
      chk("R10 write during event ignored", vsel, 0);
      otmp_raw = 0;
      step(3);
      chk("R10 stays off after cause gone", stage_en, 0);
      host_write(4'b0011, 1);
      chk("R10 rewrite accepted", vsel, 4'b0011);
      chk("R10 stage back after rewrite", stage_en, 1);
      host_read();
      host_write(4'b0000, 0);
      chk("R11 stage off at zero vsel", stage_en, 0);
   endtask

   task automatic t_lockout();
      host_write(4'b0110, 1);
      pwr_low_raw = 1;
      step(3);
      uv_trip = 1; uv_clear = 0;
      #1;
      chk("R6 vsel forced zero", vsel, 0);
      chk("R6 policy forced zero", therm_hold, 0);
      chk("R6 status forced zero", status, 0);
      pwr_low_raw = 0;
      step(1);
      uv_trip = 0;
      step(3);
      host_write(4'b1111, 0);
      chk("R7 write ignored in hysteresis band", vsel, 0);
      uv_clear = 1;
      step(1);
      host_write(4'b1111, 0);
      chk("R7 write ignored during release", vsel, 0);
      step(1);
      host_write(4'b1001, 1);
      chk("R7 write accepted after release", vsel, 4'b1001);
      chk("R7 policy accepted after release", therm_hold, 1);
   endtask

   initial begin
      t_reset();
      t_overload();
      t_pwr_low();
      t_therm_auto();
      t_therm_hold();
      t_lockout();
      done = 1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++; failures++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule